// File: doc/BRIEF.md
# Suspend Power-Down Handshake Controller

This block runs the two-way handshake that must complete before the suspend power well is switched off for a deep sleep state, and again when the system comes back out of it. A level request (`deep_req`) asks for the deep state while high and for the awake state while low. On entry the block pulls its active-low warning output low. It then waits until an external controller has pulled the active-low acknowledge input low as well, and only then drives the active-low power-removal output low. On exit it releases power first and waits a set power-stable time. It then raises the warning and waits for the acknowledge to follow it high.

The acknowledge arrives from another clock domain, so it passes through a two-flop synchronizer. A wake event that comes in while the acknowledge disagrees with the warning is not forwarded. It is remembered and released as one pulse once the two levels agree again. A board that does not take part in the handshake can wire the acknowledge straight back to the warning, and the sequence then completes with no further help. All state returns to awake on the resume-well reset, which is asserted asynchronously and released on a clock edge.

Top module: `susp_hs_ctrl`

## Requirements
- R1: While reset is asserted and on its release, `warn_n` = 1, `slp_n` = 1 and `wake_out` = 0.
- R2: From the awake state, a high `deep_req` sampled at a clock edge drives `warn_n` low right after that edge.
- R3: `slp_n` falls right after the fourth clock edge that samples `ack_n` low. Before that edge, `slp_n` stays high whatever the delay of the acknowledge after the warning.
- R4: `slp_n` is never low while `warn_n` is high.
- R5: If `deep_req` goes low while waiting for the acknowledge, `warn_n` returns high after the next edge and `slp_n` never falls.
- R6: With `slp_n` low, a low `deep_req` sampled at edge X raises `slp_n` right after X. `warn_n` stays low until edge X+STABLE_CNT and rises right after it.
- R7: After `warn_n` rises, a new request is not honoured until `ack_n` is high. With `ack_n` rising before edge 1, `warn_n` is still high after edge 3 and goes low after edge 4 if `deep_req` is held high.
- R8: When `warn_n` equals the synchronized acknowledge, each cycle in which `wake_in` is high gives exactly one cycle of `wake_out` high, right after the sampling edge.
- R9: While `warn_n` differs from the synchronized acknowledge, `wake_out` stays low.
- R10: Wakes that arrive during a blocked window merge into one pending wake. That wake is issued as a single `wake_out` pulse right after the third edge that samples the acknowledge at its matching level.
- R11: With `ack_n` wired to `warn_n`, entry drives `slp_n` low right after the fourth edge following the fall of `warn_n`, and exit completes unaided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Resume-well clock |
| rst_n | input | 1 | Resume-well reset, active low, asynchronous assert |
| deep_req | input | 1 | 1 = request deep state, 0 = request awake state |
| ack_n | input | 1 | Acknowledge from external controller, active low, asynchronous |
| wake_in | input | 1 | Wake event, one bit per cycle |
| warn_n | output | 1 | Warning, active low |
| slp_n | output | 1 | Suspend power removal, active low |
| wake_out | output | 1 | Accepted wake event pulse |

## Verification
The hardest case to reach is a wake that arrives inside the blocked window and must come out exactly once, at a cycle fixed by the synchronizer delay. The bench reaches it by holding the acknowledge away from the warning, first during entry and then during exit. It fires one or more wake pulses into that window and then releases the acknowledge, counting edges to the expected pulse. The entry latency is swept over several acknowledge delays, and the tied-back wiring is run through a full entry and exit cycle.

// File: rtl/susp_hs_pkg.sv
package susp_hs_pkg;

  typedef enum logic [2:0] {
    ST_AWAKE  = 3'd0,
    ST_WARN   = 3'd1,
    ST_SLEEP  = 3'd2,
    ST_STABLE = 3'd3,
    ST_EXIT   = 3'd4
  } hs_state_e;

endpackage

// File: rtl/susp_hs_rst_sync.sv
module susp_hs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);

  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_in_n) begin
        if (!rst_in_n) sh_q <= 1'b0;
        else           sh_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_in_n) begin
        if (!rst_in_n) sh_q <= '0;
        else           sh_q <= {sh_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_out_n = sh_q[STAGES-1];

endmodule

// File: rtl/susp_hs_sync.sv
module susp_hs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] st_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {STAGES{RST_VAL}};
        else        st_q <= {st_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = st_q[STAGES-1];

endmodule

// File: rtl/susp_hs_fsm.sv
module susp_hs_fsm
  import susp_hs_pkg::*;
#(
  parameter int STABLE_CNT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic deep_req,
  input  logic ack_s,
  output logic warn_n,
  output logic slp_n
);

  localparam int CNT_W = (STABLE_CNT > 1) ? $clog2(STABLE_CNT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CNT - 1);

  hs_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             ack_q;

  // second qualifying sample of the synchronized acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b1;
    else        ack_q <= ack_s;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_AWAKE: begin
        if (deep_req) state_d = ST_WARN;
      end
      ST_WARN: begin
        if (!deep_req)           state_d = ST_EXIT;
        else if (!ack_s && !ack_q) state_d = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (!deep_req) begin
          state_d = ST_STABLE;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_STABLE: begin
        if (cnt_q == CNT_LAST) begin
          state_d = ST_EXIT;
        end else begin
          cnt_d  = cnt_q + CNT_W'(1);
          cnt_en = 1'b1;
        end
      end
      ST_EXIT: begin
        if (ack_s) state_d = ST_AWAKE;
      end
      default: state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_AWAKE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign warn_n = !((state_q == ST_WARN) || (state_q == ST_SLEEP) ||
                    (state_q == ST_STABLE));
  assign slp_n  = (state_q != ST_SLEEP);

endmodule

// File: rtl/susp_hs_wake_gate.sv
module susp_hs_wake_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic warn_n,
  input  logic ack_s,
  input  logic wake_in,
  output logic wake_out
);

  logic blocked, req;
  logic pend_q, pend_d;
  logic wake_q, wake_d;

  always_comb begin
    blocked = (warn_n != ack_s);
    req     = wake_in | pend_q;
    pend_d  = blocked & req;
    wake_d  = !blocked & req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      wake_q <= wake_d;
    end
  end

  assign wake_out = wake_q;

endmodule

// File: rtl/susp_hs_ctrl.sv
module susp_hs_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CNT  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic deep_req,
  input  logic ack_n,
  input  logic wake_in,
  output logic warn_n,
  output logic slp_n,
  output logic wake_out
);

  logic rst_sync_n;
  logic ack_s;
  logic warn_int_n;

  susp_hs_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_sync_n)
  );

  susp_hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_ack_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (ack_n),
    .q     (ack_s)
  );

  susp_hs_fsm #(.STABLE_CNT(STABLE_CNT)) i_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .deep_req (deep_req),
    .ack_s    (ack_s),
    .warn_n   (warn_int_n),
    .slp_n    (slp_n)
  );

  susp_hs_wake_gate i_wake_gate (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .warn_n   (warn_int_n),
    .ack_s    (ack_s),
    .wake_in  (wake_in),
    .wake_out (wake_out)
  );

  assign warn_n = warn_int_n;

endmodule

// File: rtl/susp_hs_chk.sv
module susp_hs_chk (
  input logic clk,
  input logic rst_n,
  input logic deep_req,
  input logic ack_s,
  input logic warn_n,
  input logic slp_n,
  input logic wake_out
);

  AST_SLP_NEEDS_WARN: assert property (@(posedge clk) disable iff (!rst_n)
    !slp_n |-> !warn_n); // R4

  AST_SLP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slp_n) |-> (!$past(ack_s, 1) && !$past(ack_s, 2))); // R3

  AST_SLP_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slp_n) |-> $past(deep_req)); // R5

  AST_WARN_RISE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_n) |-> slp_n); // R6

  AST_WAKE_MATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_out) |-> $past(warn_n == ack_s)); // R9

endmodule

bind susp_hs_ctrl susp_hs_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .deep_req (deep_req),
  .ack_s    (ack_s),
  .warn_n   (warn_n),
  .slp_n    (slp_n),
  .wake_out (wake_out)
);

// File: tb/test_susp_hs_ctrl.sv
`timescale 1ns/1ps
module test_susp_hs_ctrl;

  localparam int S = 5;

  logic clk, rst_n, deep_req, ack_drv, tie, wake_in;
  logic ack_n, warn_n, slp_n, wake_out;
  int   checks, errors, cycles;

  assign ack_n = tie ? warn_n : ack_drv;

  susp_hs_ctrl #(.SYNC_STAGES(2), .STABLE_CNT(S)) i_susp_hs_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .deep_req (deep_req),
    .ack_n    (ack_n),
    .wake_in  (wake_in),
    .warn_n   (warn_n),
    .slp_n    (slp_n),
    .wake_out (wake_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic done();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog expired");
        done();
      end
    end
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; deep_req = 1'b0; ack_drv = 1'b1; tie = 1'b0; wake_in = 1'b0;
    #1;
    chk("R1 warn_n in reset", warn_n, 1'b1);
    chk("R1 slp_n in reset", slp_n, 1'b1);
    repeat (3) tick();
    chk("R1 wake_out in reset", wake_out, 1'b0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 warn_n after release", warn_n, 1'b1);
    chk("R1 slp_n after release", slp_n, 1'b1);

    // R8: matched wake in awake state, pulse lengths 1 and 2
    for (int len = 1; len <= 2; len++) begin
      wake_in = 1'b1;
      for (int k = 0; k < len; k++) begin
        tick();
        chk("R8 wake pulse", wake_out, 1'b1);
      end
      wake_in = 1'b0;
      tick();
      chk("R8 wake end", wake_out, 1'b0);
    end

    // R2/R3/R6/R7: sweep of acknowledge delay on entry
    for (int d = 0; d < 6; d++) begin
      deep_req = 1'b1;
      tick();
      chk("R2 warn_n low", warn_n, 1'b0);
      for (int k = 0; k < d; k++) begin
        tick();
        chk("R3 slp_n waits for ack", slp_n, 1'b1);
      end
      if (d == 3) begin
        // R9/R10: two wakes in the blocked window coalesce
        wake_in = 1'b1; tick(); wake_in = 1'b0;
        chk("R9 wake blocked", wake_out, 1'b0);
        tick();
        wake_in = 1'b1; tick(); wake_in = 1'b0;
        chk("R9 wake blocked again", wake_out, 1'b0);
      end
      ack_drv = 1'b0;
      for (int k = 1; k <= 3; k++) begin
        tick();
        chk("R3 slp_n before fourth sample", slp_n, 1'b1);
        if (d == 3) chk("R10 pending wake timing", wake_out, (k == 3));
      end
      tick();
      chk("R3 slp_n low", slp_n, 1'b0);
      if (d == 3) begin
        chk("R10 single pulse", wake_out, 1'b0);
        wake_in = 1'b1; tick(); wake_in = 1'b0;
        chk("R8 wake in sleep", wake_out, 1'b1);
        tick();
        chk("R8 wake in sleep ends", wake_out, 1'b0);
      end
      deep_req = 1'b0;
      tick();
      chk("R6 slp_n high at exit", slp_n, 1'b1);
      for (int k = 1; k < S; k++) begin
        tick();
        chk("R6 warn_n held during stable count", warn_n, 1'b0);
      end
      tick();
      chk("R6 warn_n rises", warn_n, 1'b1);
      if (d == 2) begin
        // R7/R9/R10: ack held low, new request and wake in exit window
        deep_req = 1'b1;
        wake_in = 1'b1; tick(); wake_in = 1'b0;
        chk("R9 wake blocked on exit", wake_out, 1'b0);
        tick(); tick();
        chk("R7 no new request before ack", warn_n, 1'b1);
        ack_drv = 1'b1;
        for (int k = 1; k <= 3; k++) begin
          tick();
          chk("R7 warn_n high", warn_n, 1'b1);
          chk("R10 pending wake on exit", wake_out, (k == 3));
        end
        tick();
        chk("R7 request honoured", warn_n, 1'b0);
        // R5: abort before acknowledge
        deep_req = 1'b0;
        tick();
        chk("R5 warn_n back high", warn_n, 1'b1);
        for (int k = 0; k < 4; k++) begin
          tick();
          chk("R5 slp_n stays high", slp_n, 1'b1);
        end
      end else begin
        ack_drv = 1'b1;
        repeat (4) tick();
      end
    end

    // R11: acknowledge tied back to warning
    tie = 1'b1;
    deep_req = 1'b1;
    tick();
    chk("R11 warn_n low", warn_n, 1'b0);
    for (int k = 1; k <= 3; k++) begin
      tick();
      chk("R11 slp_n high", slp_n, 1'b1);
    end
    tick();
    chk("R11 slp_n low", slp_n, 1'b0);
    deep_req = 1'b0;
    tick();
    chk("R11 slp_n released", slp_n, 1'b1);
    repeat (S - 1) tick();
    tick();
    chk("R11 warn_n rises", warn_n, 1'b1);
    deep_req = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      tick();
      chk("R11 exit completes", warn_n, 1'b1);
    end
    tick();
    chk("R11 re-entry", warn_n, 1'b0);
    deep_req = 1'b0;
    repeat (4) tick();
    chk("R4 idle slp_n", slp_n, 1'b1);
    done();
  end

endmodule